// File: doc/BRIEF.md
# I/Q Interleaved DAC Bus Driver

This block sits on the host side of a dual digital-to-analog converter whose two channels share one 8-bit data bus. It takes in-phase (I) and quadrature (Q) sample pairs through a valid/ready handshake. It drives the converter clock, an active-low chip select, a power-down line and an enable line. Each pair is put on the bus as two half-cycles. The Q sample is held while the converter clock is high and is captured by the converter on the falling edge. The I sample is held while the clock is low and is captured on the next rising edge. On that rising edge the receiving side updates both outputs of the pair together.

The driver runs from a system clock at twice the converter clock rate. Every converter clock edge and every bus change is launched from a system clock edge. The converter clock and the bus change on the same edge, so each sample has one full system period of setup before the edge that captures it and zero hold after it.

A two-bit mode input selects shutdown, standby or active. When the mode becomes active, the driver waits a programmable number of cycles for the converter to wake up. Only then does it assert chip select and begin accepting pairs.

Back-pressure: `in_ready` is high only in a cycle in which the converter clock is low, chip select is asserted and the mode is active. A pair transfers on the system clock edge where `in_valid` and `in_ready` are both high. The source may hold `in_valid` high for as long as it likes; data is taken only on a transfer edge. At most one pair is accepted every two cycles.

If no pair is offered in a cycle where one could be taken (a load slot), the behaviour depends on `hold_on_empty_i`. With it low, the driver repeats the last pair. With it high, it freezes the converter clock and the bus and raises `underflow_o`.

Top module: `iq_bus_driver`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the driver holds the following values: `dac_cs_n_o`=1, `dac_clk_o`=0, `dac_pd_o`=1, `dac_en_o`=0, `in_ready`=0, `underflow_o`=0 and `dac_bus_o`=0.
- R2: `mode_i` is decoded as follows: 2'b00 is shutdown (pd=1, en=0), 2'b01 is standby (pd=0, en=0), and 2'b10 or 2'b11 is active (pd=0, en=1). `dac_pd_o` and `dac_en_o` follow `mode_i` one cycle later.
- R3: After `dac_en_o` rises, `dac_cs_n_o` falls exactly `wake_cycles_i`+1 cycles later. `in_ready` stays low until then.
- R4: `in_ready` is high only when `dac_clk_o` is 0, `dac_cs_n_o` is 0 and `mode_i` is active.
- R5: Consider a pair accepted on edge E. From E, `dac_clk_o`=1 and `dac_bus_o` holds the Q sample. From E+1, `dac_clk_o`=0 and `dac_bus_o` holds the I sample. `dac_bus_o` changes only on edges where `dac_clk_o` also changes.
- R6: When pairs are offered back to back, one pair is accepted every two cycles. `in_ready` is high again in the cycle in which the previous pair's I sample is driven.
- R7: With `hold_on_empty_i`=0, a load slot without `in_valid` still toggles `dac_clk_o`. The bus then repeats the last Q sample followed by the last I sample, and `underflow_o` stays 0.
- R8: With `hold_on_empty_i`=1, a load slot without `in_valid` leaves `dac_clk_o` at 0 and the bus unchanged, and raises `underflow_o` in the following cycle. `underflow_o` returns to 0 on the cycle after the next accepted pair.
- R9: When the mode leaves active, no further pair is accepted. If `dac_clk_o` is high at that moment, the pair in progress finishes with its I sample. `dac_cs_n_o` then returns to 1 with `dac_clk_o` low, and `dac_bus_o` keeps its last value while `in_valid` data is ignored.
- R10: `dac_clk_o` is 0 whenever `dac_cs_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the converter clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Power mode: 00 shutdown, 01 standby, 1x active |
| hold_on_empty_i | input | 1 | 1: freeze and flag on starvation; 0: repeat last pair |
| wake_cycles_i | input | WAKE_W (12) | Cycles to wait after enable before selecting the converter |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Driver can take a pair this cycle |
| in_i | input | DATA_W (8) | In-phase sample |
| in_q | input | DATA_W (8) | Quadrature sample |
| dac_clk_o | output | 1 | Converter clock |
| dac_bus_o | output | DATA_W (8) | Shared converter data bus |
| dac_cs_n_o | output | 1 | Converter chip select, active low |
| dac_pd_o | output | 1 | Converter power-down line |
| dac_en_o | output | 1 | Converter enable line |
| underflow_o | output | 1 | A load slot was missed in hold mode |

## Verification
The bench sets inputs on falling system clock edges and samples outputs on later falling edges. Each expected value is therefore read exactly one rising edge after the edge that must produce it. A pair accepted on edge E is checked as its Q sample at the next falling edge and as its I sample one cycle after that. Underflow and the repeated pair likewise appear one cycle after the starved load slot. The chip select is checked at each of the `wake_cycles_i`+2 falling edges that follow the mode change. It must read high at every one of them except the last. When leaving active with the clock high, the bench expects one more I cycle with chip select still low, then chip select high on the cycle after that.

// File: rtl/iq_bus_driver_pkg.sv
package iq_bus_driver_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_WAKE = 2'd1,
    PS_RUN  = 2'd2
  } pwr_state_t;

  localparam logic [1:0] MODE_SHUTDOWN = 2'b00;
  localparam logic [1:0] MODE_STANDBY  = 2'b01;

  function automatic logic mode_is_active(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/iqd_power_seq.sv
module iqd_power_seq
  import iq_bus_driver_pkg::*;
#(
  parameter int WAKE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [WAKE_W-1:0] wake_cycles_i,
  input  logic              conv_clk_i,
  output logic              active_o,
  output logic              run_o,
  output logic              cs_n_o,
  output logic              pd_o,
  output logic              en_o
);
  pwr_state_t        state_q, state_d;
  logic [WAKE_W-1:0] cnt_q, cnt_d;

  assign active_o = mode_is_active(mode_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PS_IDLE: begin
        if (active_o) begin
          state_d = PS_WAKE;
          cnt_d   = '0;
        end
      end
      PS_WAKE: begin
        if (!active_o) begin
          state_d = PS_IDLE;
        end else if (cnt_q >= wake_cycles_i) begin
          state_d = PS_RUN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PS_RUN: begin
        // leave only between pairs, when the converter clock is low
        if (!active_o && !conv_clk_i) state_d = PS_IDLE;
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
      pd_o    <= 1'b1;
      en_o    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pd_o    <= (mode_i == MODE_SHUTDOWN);
      en_o    <= active_o;
    end
  end

  assign run_o  = (state_q == PS_RUN);
  assign cs_n_o = !run_o;
endmodule

// File: rtl/iqd_lane_mux.sv
module iqd_lane_mux #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              active_i,
  input  logic              hold_on_empty_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_i_i,
  input  logic [DATA_W-1:0] in_q_i,
  output logic              ready_o,
  output logic              conv_clk_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              underflow_o
);
  logic [DATA_W-1:0] i_hold_q;
  logic [DATA_W-1:0] q_last_q;
  logic              slot;
  logic              fire;

  // a load slot is a low phase of the converter clock while selected
  assign slot    = run_i && active_i && !conv_clk_o;
  assign ready_o = slot;
  assign fire    = slot && in_valid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_clk_o  <= 1'b0;
      bus_o       <= '0;
      i_hold_q    <= '0;
      q_last_q    <= '0;
      underflow_o <= 1'b0;
    end else begin
      underflow_o <= 1'b0;
      if (!run_i) begin
        conv_clk_o <= 1'b0;
      end else if (conv_clk_o) begin
        // falling edge: Q is captured now, present I for the rising edge
        conv_clk_o <= 1'b0;
        bus_o      <= i_hold_q;
      end else if (fire) begin
        conv_clk_o <= 1'b1;
        bus_o      <= in_q_i;
        q_last_q   <= in_q_i;
        i_hold_q   <= in_i_i;
      end else if (slot) begin
        if (hold_on_empty_i) begin
          underflow_o <= 1'b1;
        end else begin
          conv_clk_o <= 1'b1;
          bus_o      <= q_last_q;
        end
      end
    end
  end
endmodule

// File: rtl/iq_bus_driver.sv
module iq_bus_driver
  import iq_bus_driver_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WAKE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              hold_on_empty_i,
  input  logic [WAKE_W-1:0] wake_cycles_i,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  output logic              dac_clk_o,
  output logic [DATA_W-1:0] dac_bus_o,
  output logic              dac_cs_n_o,
  output logic              dac_pd_o,
  output logic              dac_en_o,
  output logic              underflow_o
);
  logic active;
  logic run;

  iqd_power_seq #(.WAKE_W(WAKE_W)) u_pwr (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .wake_cycles_i(wake_cycles_i),
    .conv_clk_i   (dac_clk_o),
    .active_o     (active),
    .run_o        (run),
    .cs_n_o       (dac_cs_n_o),
    .pd_o         (dac_pd_o),
    .en_o         (dac_en_o)
  );

  iqd_lane_mux #(.DATA_W(DATA_W)) u_mux (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_i          (run),
    .active_i       (active),
    .hold_on_empty_i(hold_on_empty_i),
    .in_valid_i     (in_valid),
    .in_i_i         (in_i),
    .in_q_i         (in_q),
    .ready_o        (in_ready),
    .conv_clk_o     (dac_clk_o),
    .bus_o          (dac_bus_o),
    .underflow_o    (underflow_o)
  );
endmodule

// File: rtl/iq_bus_driver_chk.sv
module iq_bus_driver_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_i,
  input logic [DATA_W-1:0] in_q,
  input logic              dac_clk_o,
  input logic [DATA_W-1:0] dac_bus_o,
  input logic              dac_cs_n_o,
  input logic              underflow_o
);
  // R10
  clk_idle_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n_o |-> !dac_clk_o);

  // R4
  ready_only_in_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!dac_clk_o && !dac_cs_n_o));

  // R5
  q_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (dac_clk_o && dac_bus_o == $past(in_q)));

  // R5
  i_follows_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 (!dac_clk_o && dac_bus_o == $past(in_i, 2)));

  // R5
  bus_moves_with_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_bus_o != $past(dac_bus_o)) |-> (dac_clk_o != $past(dac_clk_o)));

  // R8
  underflow_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> (!dac_clk_o && $stable(dac_bus_o)));
endmodule

bind iq_bus_driver iq_bus_driver_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_i       (in_i),
  .in_q       (in_q),
  .dac_clk_o  (dac_clk_o),
  .dac_bus_o  (dac_bus_o),
  .dac_cs_n_o (dac_cs_n_o),
  .underflow_o(underflow_o)
);

// File: tb/test_iq_bus_driver.sv
`timescale 1ns/1ps
module test_iq_bus_driver;
  localparam int DW = 8;
  localparam int WW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic          hold_on_empty_i = 1'b0;
  logic [WW-1:0] wake_cycles_i = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_i = '0;
  logic [DW-1:0] in_q = '0;
  logic          dac_clk_o;
  logic [DW-1:0] dac_bus_o;
  logic          dac_cs_n_o;
  logic          dac_pd_o;
  logic          dac_en_o;
  logic          underflow_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  iq_bus_driver #(.DATA_W(DW), .WAKE_W(WW)) i_iq_bus_driver (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .hold_on_empty_i(hold_on_empty_i),
    .wake_cycles_i(wake_cycles_i), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .dac_clk_o(dac_clk_o), .dac_bus_o(dac_bus_o),
    .dac_cs_n_o(dac_cs_n_o), .dac_pd_o(dac_pd_o), .dac_en_o(dac_en_o),
    .underflow_o(underflow_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "cs_n", dac_cs_n_o, 1);
    check("R1", "clk", dac_clk_o, 0);
    check("R1", "pd", dac_pd_o, 1);
    check("R1", "en", dac_en_o, 0);
    check("R1", "ready", in_ready, 0);
    check("R1", "underflow", underflow_o, 0);
    check("R1", "bus", dac_bus_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "cs_n after release", dac_cs_n_o, 1);
    check("R2", "pd in shutdown", dac_pd_o, 1);
  endtask

  // R3: mode set at a falling edge; cs_n must fall on the (w+1)-th edge after enable rises
  task automatic t_wake(input int w);
    wake_cycles_i = WW'(w);
    mode_i = 2'b10;
    for (int k = 0; k <= w + 1; k++) begin
      @(negedge clk);
      if (k == 0) begin
        check("R2", "en active", dac_en_o, 1);
        check("R2", "pd active", dac_pd_o, 0);
      end
      check("R3", $sformatf("cs_n at cycle %0d", k), dac_cs_n_o, (k == w + 1) ? 0 : 1);
      if (k <= w) check("R3", "ready during wake", in_ready, 0);
    end
    #1;
    check("R4", "ready once selected", in_ready, 1);
  endtask

  // called at a falling edge with the converter clock low
  task automatic send_pair(input logic [DW-1:0] iv, input logic [DW-1:0] qv, input bit expect_now);
    in_i = iv; in_q = qv; in_valid = 1'b1;
    #1;
    if (expect_now) check("R6", "ready back to back", in_ready, 1);
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R5", "clk high with Q", dac_clk_o, 1);
    check("R5", "Q on bus", dac_bus_o, qv);
    check("R8", "no underflow after accept", underflow_o, 0);
    #1;
    check("R4", "ready low in high phase", in_ready, 0);
    @(negedge clk);
    check("R5", "clk low with I", dac_clk_o, 0);
    check("R5", "I on bus", dac_bus_o, iv);
  endtask

  task automatic t_stream();
    send_pair(8'h11, 8'hA5, 1'b1);
    send_pair(8'h7F, 8'h80, 1'b1);
    send_pair(8'hFF, 8'h00, 1'b1);
  endtask

  task automatic t_repeat();
    hold_on_empty_i = 1'b0;
    for (int r = 0; r < 2; r++) begin
      @(negedge clk);
      check("R7", "clk toggles high", dac_clk_o, 1);
      check("R7", "last Q repeated", dac_bus_o, 8'h00);
      check("R7", "no underflow", underflow_o, 0);
      @(negedge clk);
      check("R7", "clk toggles low", dac_clk_o, 0);
      check("R7", "last I repeated", dac_bus_o, 8'hFF);
    end
  endtask

  task automatic t_hold();
    hold_on_empty_i = 1'b1;
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      check("R8", "clk frozen", dac_clk_o, 0);
      check("R8", "bus frozen", dac_bus_o, 8'hFF);
      check("R8", "underflow raised", underflow_o, 1);
    end
    send_pair(8'h3C, 8'hC3, 1'b1);
    hold_on_empty_i = 1'b0;
  endtask

  // leave active while the clock is high, then check deselect and ignored input
  task automatic t_exit();
    in_i = 8'h5A; in_q = 8'hA6; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R5", "Q before exit", dac_bus_o, 8'hA6);
    mode_i = 2'b01;
    in_valid = 1'b1; in_i = 8'h99; in_q = 8'h66;
    #1;
    check("R9", "ready drops on exit", in_ready, 0);
    @(negedge clk);
    check("R9", "pair completes with I", dac_bus_o, 8'h5A);
    check("R9", "cs still low for I", dac_cs_n_o, 0);
    check("R2", "en low in standby", dac_en_o, 0);
    check("R2", "pd low in standby", dac_pd_o, 0);
    @(negedge clk);
    check("R9", "cs high after exit", dac_cs_n_o, 1);
    check("R10", "clk low when deselected", dac_clk_o, 0);
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      check("R9", "bus keeps last I", dac_bus_o, 8'h5A);
      check("R9", "no ready while idle", in_ready, 0);
    end
    in_valid = 1'b0;
    mode_i = 2'b00;
    @(negedge clk);
    check("R2", "pd in shutdown", dac_pd_o, 1);
    check("R2", "en in shutdown", dac_en_o, 0);
  endtask

  initial begin
    #160000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_wake(3);
    t_stream();
    t_repeat();
    t_hold();
    t_exit();
    t_wake(0);
    send_pair(8'h01, 8'hFE, 1'b1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule